// File: doc/BRIEF.md
# Reconfigurable Region Isolation Controller

This block keeps a reconfigurable logic region cut off from the static part of the chip while that region is rewritten. Software uses four 32-bit registers on a simple word-addressed bus. It asks for isolation ("halt"), asserts a reset into the region while it is isolated, and then asks for release ("run"). It follows each request through a status register holding two completion flags, and at most one of those flags is set at any time. The block drives an isolation level (`region_freeze`) to the gating logic at the region boundary, and a reset level (`region_reset`) into the region.

A halt request raises `region_freeze` at once. The halt is complete when one of two things happens, and a parameter selects which. In the first option, the region reports through `drain_idle` that its in-flight traffic has stopped. In the second option, a fixed number of settle cycles has elapsed. A run request lowers the region reset first and the isolation one cycle later, and then swaps the completion flags. A request that does not fit the current state, or that is malformed, changes nothing. It leaves a mark in a sticky fault register, and software clears that register by writing 1.

The bus has no back-pressure. Every access completes in the cycle it is presented. Read data appears on `bus_rdata` after the clock edge that samples the read, and it holds until the next read.

Top module: `region_iso_ctl`

## Requirements
- R1: Word 0 is status, word 1 is control, word 2 is the fault register and word 3 is the identity register. The identity register reads the constant 0x00000002. A read presented at one rising edge shows its data on `bus_rdata` after that edge.
- R2: After reset, status reads 2 (run-done set), control reads 0, the fault register reads 0, and `region_freeze` and `region_reset` are both low.
- R3: Status bit 0 is halt-done and status bit 1 is run-done. The two are never set together.
- R4: Writing exactly control bit 0 while run-done is set raises `region_freeze` after that write's edge and clears run-done. In drain mode, `drain_idle` is registered once, and halt-done sets at the edge after a registered idle value is seen.
- R5: In settle mode with N settle cycles, halt-done sets at the N-th rising edge after the edge that accepted the halt write. `drain_idle` is ignored in this mode.
- R6: Writing 0 to control clears every pending request bit. During a halt still in progress, it drops `region_freeze` one edge later and restores run-done. Once halted, it leaves halt-done and `region_freeze` set.
- R7: `region_reset` equals control bit 1 while halt-done is set and the release sequence has not started. At any other time it stays low, whatever bit 1 holds.
- R8: Writing exactly control bit 2 while halted clears `region_reset` at that edge. `region_freeze` falls at the next edge. At the edge after that, halt-done clears and run-done sets.
- R9: A halt request made while run-done is clear sets fault bit 0. It leaves control, status and outputs unchanged.
- R10: A run request made while halt-done is clear, or while a release is already under way, sets fault bit 2. It leaves control, status and outputs unchanged.
- R11: A control write with more than one of bits 0 to 2 set, or with any bit above bit 2 set, sets fault bit 1. It changes nothing else.
- R12: Fault bits accumulate until a write to the fault register with data bit 0 set clears all of them. A read straight after that write returns 0. Writing the fault register with bit 0 clear has no effect.
- R13: Writes to the status and identity registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| drain_idle | input | 1 | Region reports no traffic in flight (drain mode only) |
| region_freeze | output | 1 | Isolate region from static logic |
| region_reset | output | 1 | Reset into the region |

## Verification
The properties assume that `drain_idle` is sampled only on rising edges and that the bus carries at most one access per cycle. They also assume that software writes whole values to control, so that a write of a single request bit always replaces the earlier request. The bench drives all inputs on the falling edge and keeps `bus_en` low between accesses. It holds `drain_idle` low while it steps a halt through the settle-count instance, so that the two bench instances reach the halted state in a known order. It pulses `drain_idle` for exactly one cycle, so that the registered idle sample is the only path to completion.

// File: rtl/iso_pkg.sv
package iso_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned WORD_AW = 2;
  localparam int unsigned REQ_W   = 3;

  // word indices
  localparam logic [WORD_AW-1:0] W_STATUS = 2'd0;
  localparam logic [WORD_AW-1:0] W_CTRL   = 2'd1;
  localparam logic [WORD_AW-1:0] W_FAULT  = 2'd2;
  localparam logic [WORD_AW-1:0] W_ID     = 2'd3;

  // control request bit positions
  localparam int unsigned B_HALT = 0;
  localparam int unsigned B_RST  = 1;
  localparam int unsigned B_RUN  = 2;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_HELD    = 3'd2,
    ST_THAW    = 3'd3,
    ST_RELEASE = 3'd4
  } iso_state_e;
endpackage

// File: rtl/iso_regs.sv
module iso_regs
  import iso_pkg::*;
#(
  parameter logic [REG_W-1:0] ID_VALUE = 32'h0000_0002
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [WORD_AW-1:0] bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  input  logic               is_running,
  input  logic               is_held,
  input  logic               halt_done,
  input  logic               run_done,
  output logic [REG_W-1:0]   bus_rdata,
  output logic [REQ_W-1:0]   ctrl_q,
  output logic               go_halt,
  output logic               go_run
);
  logic             wr_ctrl, wr_fault, fault_clr;
  logic [REQ_W-1:0] req;
  logic             extra_bits, many_bits;
  logic             bad_shape, bad_halt, bad_run, accept;
  logic [REQ_W-1:0] fault_q;

  always_comb begin
    wr_ctrl    = bus_en & bus_we & (bus_addr == W_CTRL);
    wr_fault   = bus_en & bus_we & (bus_addr == W_FAULT);
    fault_clr  = wr_fault & bus_wdata[0];
    req        = bus_wdata[REQ_W-1:0];
    extra_bits = |bus_wdata[REG_W-1:REQ_W];
    many_bits  = ($countones(req) > 1);
    bad_shape  = wr_ctrl & (many_bits | extra_bits);
    bad_halt   = wr_ctrl & ~bad_shape & req[B_HALT] & ~is_running;
    bad_run    = wr_ctrl & ~bad_shape & req[B_RUN] & ~is_held;
    accept     = wr_ctrl & ~(bad_shape | bad_halt | bad_run);
    go_halt    = accept & req[B_HALT];
    go_run     = accept & req[B_RUN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (accept) begin
      ctrl_q <= req;
    end
  end

  // fault bit order: [B_RUN] refused run, [B_RST] malformed, [B_HALT] refused halt
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= '0;
    end else if (fault_clr) begin
      fault_q <= '0;
    end else begin
      fault_q[B_HALT] <= fault_q[B_HALT] | bad_halt;
      fault_q[B_RST]  <= fault_q[B_RST]  | bad_shape;
      fault_q[B_RUN]  <= fault_q[B_RUN]  | bad_run;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_en && !bus_we) begin
      case (bus_addr)
        W_STATUS: bus_rdata <= {{(REG_W-2){1'b0}}, run_done, halt_done};
        W_CTRL:   bus_rdata <= {{(REG_W-REQ_W){1'b0}}, ctrl_q};
        W_FAULT:  bus_rdata <= {{(REG_W-REQ_W){1'b0}}, fault_q};
        default:  bus_rdata <= ID_VALUE;
      endcase
    end
  end

  // R9 R10 R11: a refused control write leaves the request register untouched
  assert_refused_keeps_ctrl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !accept) |=> $stable(ctrl_q));
  assert_fault_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_clr |=> ((fault_q & $past(fault_q)) == $past(fault_q)));
  assert_fault_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fault_clr |=> (fault_q == '0));
endmodule

// File: rtl/iso_settle.sv
module iso_settle #(
  parameter bit          USE_DRAIN     = 1'b1,
  parameter int unsigned SETTLE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic drain_idle,
  output logic quiet
);
  generate
    if (USE_DRAIN) begin : g_drain
      logic idle_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idle_q <= 1'b0;
        else        idle_q <= drain_idle;
      end
      assign quiet = arm & idle_q;

      assert_quiet_from_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |-> $past(drain_idle));
    end else begin : g_count
      localparam int unsigned CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (arm) cnt_q <= cnt_q + 1'b1;
        else          cnt_q <= '0;
      end
      assign quiet = arm & (cnt_q == CNT_LAST);

      assert_settle_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (SETTLE_CYCLES > 1 && quiet) |-> $past(arm));
    end
  endgenerate
endmodule

// File: rtl/iso_seq.sv
module iso_seq
  import iso_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go_halt,
  input  logic go_run,
  input  logic halt_req,
  input  logic quiet,
  output logic arm,
  output logic is_running,
  output logic is_held,
  output logic halt_done,
  output logic run_done,
  output logic freeze_o
);
  iso_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:     if (go_halt) state_d = ST_DRAIN;
      ST_DRAIN:   if (!halt_req) state_d = ST_RUN;
                  else if (quiet) state_d = ST_HELD;
      ST_HELD:    if (go_run) state_d = ST_THAW;
      ST_THAW:    state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_RUN;
      default:    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  always_comb begin
    arm        = (state_q == ST_DRAIN);
    is_running = (state_q == ST_RUN);
    is_held    = (state_q == ST_HELD);
    run_done   = (state_q == ST_RUN);
    halt_done  = (state_q == ST_HELD) || (state_q == ST_THAW) || (state_q == ST_RELEASE);
    freeze_o   = (state_q == ST_DRAIN) || (state_q == ST_HELD) || (state_q == ST_THAW);
  end

  assert_freeze_from_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freeze_o) |-> $past(go_halt));
  assert_halt_after_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_done) |-> $past(quiet));
  assert_done_swap_after_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_done) |-> (!freeze_o && $past(!freeze_o) && run_done));
endmodule

// File: rtl/region_iso_ctl.sv
module region_iso_ctl
  import iso_pkg::*;
#(
  parameter bit               USE_DRAIN     = 1'b1,
  parameter int unsigned      SETTLE_CYCLES = 8,
  parameter logic [31:0]      ID_VALUE      = 32'h0000_0002
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        drain_idle,
  output logic        region_freeze,
  output logic        region_reset
);
  logic [REQ_W-1:0] ctrl_q;
  logic go_halt, go_run, quiet, arm;
  logic is_running, is_held, halt_done, run_done;

  iso_regs #(.ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .is_running(is_running), .is_held(is_held),
    .halt_done(halt_done), .run_done(run_done),
    .bus_rdata(bus_rdata), .ctrl_q(ctrl_q),
    .go_halt(go_halt), .go_run(go_run)
  );

  iso_settle #(.USE_DRAIN(USE_DRAIN), .SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .arm(arm), .drain_idle(drain_idle), .quiet(quiet)
  );

  iso_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .go_halt(go_halt), .go_run(go_run), .halt_req(ctrl_q[B_HALT]), .quiet(quiet),
    .arm(arm), .is_running(is_running), .is_held(is_held),
    .halt_done(halt_done), .run_done(run_done), .freeze_o(region_freeze)
  );

  assign region_reset = ctrl_q[B_RST] & is_held;

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_done && run_done));
  assert_reset_only_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    region_reset |-> (halt_done && region_freeze));
  assert_reset_drops_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(region_freeze) |-> $past(!region_reset));
endmodule

// File: tb/region_iso_ctl_bench.sv
module region_iso_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE_N   = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we, drain_idle;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] rdata_a, rdata_b;
  logic        frz_a, frz_b, rst_a, rst_b;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_iso_ctl u_region_iso_ctl (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .drain_idle(drain_idle),
    .region_freeze(frz_a), .region_reset(rst_a)
  );

  region_iso_ctl #(.USE_DRAIN(1'b0), .SETTLE_CYCLES(SETTLE_N)) u_region_iso_ctl_timed (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .drain_idle(drain_idle),
    .region_freeze(frz_b), .region_reset(rst_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R2 freeze after reset", {31'b0, frz_a}, 32'd0);
    chk("R2 region reset after reset", {31'b0, rst_a}, 32'd0);
    rd(2'd0); chk("R2 status after reset", rdata_a, 32'd2);
    rd(2'd1); chk("R2 control after reset", rdata_a, 32'd0);
    rd(2'd2); chk("R2 fault after reset", rdata_a, 32'd0);
    rd(2'd3); chk("R1 identity", rdata_a, 32'd2);
  endtask

  task automatic t_ro_writes;
    wr(2'd0, 32'd3); wr(2'd3, 32'h55);
    rd(2'd0); chk("R13 status unchanged", rdata_a, 32'd2);
    rd(2'd3); chk("R13 identity unchanged", rdata_a, 32'd2);
  endtask

  task automatic t_illegal_run;
    wr(2'd1, 32'd4);
    chk("R10 freeze unchanged", {31'b0, frz_a}, 32'd0);
    rd(2'd2); chk("R10 fault bit 2", rdata_a, 32'd4);
    rd(2'd1); chk("R10 control unchanged", rdata_a, 32'd0);
    rd(2'd0); chk("R10 status unchanged", rdata_a, 32'd2);
  endtask

  task automatic t_sticky;
    wr(2'd2, 32'd0);
    rd(2'd2); chk("R12 zero write keeps fault", rdata_a, 32'd4);
    wr(2'd2, 32'd1);
    rd(2'd2); chk("R12 clear reads zero", rdata_a, 32'd0);
  endtask

  task automatic t_bad_shape;
    wr(2'd1, 32'd5);
    rd(2'd2); chk("R11 two bits flagged", rdata_a, 32'd2);
    wr(2'd1, 32'h8);
    rd(2'd1); chk("R11 control unchanged", rdata_a, 32'd0);
    rd(2'd0); chk("R11 status unchanged", rdata_a, 32'd2);
    chk("R11 freeze unchanged", {31'b0, frz_a}, 32'd0);
    wr(2'd1, 32'd4);
    rd(2'd2); chk("R12 fault bits accumulate", rdata_a, 32'd6);
    wr(2'd2, 32'd1);
  endtask

  task automatic t_reset_while_running;
    wr(2'd1, 32'd2);
    chk("R7 no region reset while running", {31'b0, rst_a}, 32'd0);
    rd(2'd1); chk("R7 control holds bit 1", rdata_a, 32'd2);
    wr(2'd1, 32'd0);
  endtask

  task automatic t_abort;
    drain_idle = 1'b0;
    wr(2'd1, 32'd1);
    chk("R4 freeze rises after request", {31'b0, frz_a}, 32'd1);
    wr(2'd1, 32'd0);
    @(negedge clk);
    chk("R6 withdraw drops freeze", {31'b0, frz_a}, 32'd0);
    chk("R6 withdraw drops freeze timed", {31'b0, frz_b}, 32'd0);
    rd(2'd0); chk("R6 run-done restored", rdata_a, 32'd2);
    rd(2'd2); chk("R6 withdraw is legal", rdata_a, 32'd0);
  endtask

  task automatic t_halt;
    drain_idle = 1'b0;
    wr(2'd1, 32'd1);
    for (int i = 1; i <= SETTLE_N; i++) begin
      rd(2'd0);
      chk("R5 settle not yet done", rdata_b, 32'd0);
      chk("R4 drain not yet done", rdata_a, 32'd0);
    end
    rd(2'd0); chk("R5 settle done after N edges", rdata_b, 32'd1);
    chk("R4 freeze held while draining", {31'b0, frz_a}, 32'd1);
    drain_idle = 1'b1;
    @(negedge clk);
    drain_idle = 1'b0;
    rd(2'd0); chk("R4 not done at idle sample edge", rdata_a, 32'd0);
    rd(2'd0); chk("R4 done after registered idle", rdata_a, 32'd1);
    chk("R5 timed freeze high", {31'b0, frz_b}, 32'd1);
  endtask

  task automatic t_illegal_halt;
    wr(2'd1, 32'd1);
    rd(2'd2); chk("R9 fault bit 0", rdata_a, 32'd1);
    rd(2'd0); chk("R9 status unchanged", rdata_a, 32'd1);
    rd(2'd1); chk("R9 control unchanged", rdata_a, 32'd1);
    chk("R9 freeze unchanged", {31'b0, frz_a}, 32'd1);
    wr(2'd2, 32'd1);
  endtask

  task automatic t_region_reset;
    wr(2'd1, 32'd2);
    chk("R7 region reset follows bit", {31'b0, rst_a}, 32'd1);
    chk("R7 region reset timed", {31'b0, rst_b}, 32'd1);
    wr(2'd1, 32'd0);
    chk("R6 zero drops region reset", {31'b0, rst_a}, 32'd0);
    chk("R6 zero keeps freeze", {31'b0, frz_a}, 32'd1);
    rd(2'd0); chk("R6 zero keeps halt-done", rdata_a, 32'd1);
    wr(2'd1, 32'd2);
  endtask

  task automatic t_thaw;
    wr(2'd1, 32'd4);
    chk("R8 region reset falls first", {31'b0, rst_a}, 32'd0);
    chk("R8 freeze still high", {31'b0, frz_a}, 32'd1);
    @(negedge clk);
    chk("R8 freeze falls next edge", {31'b0, frz_a}, 32'd0);
    rd(2'd0); chk("R8 halt-done kept one more edge", rdata_a, 32'd1);
    rd(2'd0); chk("R8 run-done set", rdata_a, 32'd2);
    chk("R8 timed run-done set", rdata_b, 32'd2);
    rd(2'd2); chk("R8 no fault", rdata_a, 32'd0);
    wr(2'd1, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    drain_idle = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ro_writes();
    t_illegal_run();
    t_sticky();
    t_bad_shape();
    t_reset_while_running();
    t_abort();
    t_halt();
    t_illegal_halt();
    t_region_reset();
    t_thaw();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule